// File: doc/BRIEF.md
# Serial Configuration Port with Control Register Bank

This block is the configuration front end of a stereo audio converter. In software mode, a host drives three wires: a select line, a serial clock and serial data. Over them it writes 16-bit frames into four 9-bit control registers. Each frame starts with five bits that must be zero. Two address bits follow, then nine data bits, most significant bit first. The block commits the frame to the addressed register when the select line falls.

The stored words are decoded onto named control outputs:
- per-channel attenuation and its load flag,
- zero detect and analog-ground force,
- de-emphasis rate and mute,
- output routing type, coupling of the right attenuation to the left one,
- word length, frame-sync polarity and input format.

When the mode input is low, the block runs in hardware mode. The same three wires then act as direct controls: the select line becomes an active-low mute, and the clock and data lines become the two de-emphasis bits. Every other control reports its power-up value. Serial traffic is ignored in this mode, and the stored words are kept for when software mode returns. The pins are assumed to be sampled by, and synchronous to, the block clock, at least two clock cycles per serial phase.

Top module: `ssp_regfile`

## Requirements
- R1: After a synchronous active-low reset, the four registers hold 0x0FF, 0x0FF, 0x000 and 0x090 for addresses 0 to 3. In software mode this is seen on the decoded outputs.
- R2: In software mode, while the select line is high, one bit of serial data is taken on each rising edge of the serial clock, most significant bit first. The frame is committed on the falling edge of the select line. Only the addressed register changes.
- R3: Frame bits 10:9, sent after the five reserved bits, select the register: 00 register 0, 01 register 1, 10 register 2, 11 register 3. Bits 8:0 are the data.
- R4: A frame in which any of the five leading reserved bits is 1 is discarded, and every register keeps its value.
- R5: A frame that received any number of serial clock rises other than 16 before the select line falls is discarded.
- R6: Register 2 decodes as: bit 4 zero-detect enable, bit 3 analog-ground force, bits 2:1 de-emphasis select (00 off, 01 48 kHz, 10 44.1 kHz, 11 32 kHz), bit 0 mute.
- R7: Register 3 decodes as: bits 7:4 output type, bit 3 attenuation coupling, bit 2 word length (1 = 18 bit), bit 1 frame-sync polarity, bit 0 input format (1 = I2S).
- R8: Registers 0 and 1 give the left and right attenuation in bits 7:0, with a load flag in bit 8.
- R9: When the coupling bit of register 3 is 1, the right attenuation and its load flag follow register 0 instead of register 1.
- R10: With the mode input at 0, mute equals the inverse of the select line and de-emphasis select equals {clock pin, data pin}. Every other output shows the reset-value decode: attenuation 0xFF, load flags 0, output type 1001, all other bits 0.
- R11: With the mode input at 0, serial activity writes nothing. When the mode input returns to 1, the outputs again show the words held before the switch.
- R12: A committed frame reaches the outputs on the second clock edge after the select line is seen low, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sw | input | 1 | 1 = serial software mode, 0 = direct hardware mode |
| pin_en | input | 1 | Serial select / latch line, or active-low mute in hardware mode |
| pin_sck | input | 1 | Serial clock, or de-emphasis bit 1 in hardware mode |
| pin_sdi | input | 1 | Serial data, or de-emphasis bit 0 in hardware mode |
| att_left | output | 8 | Left attenuation code |
| att_left_ld | output | 1 | Left attenuation load flag |
| att_right | output | 8 | Right attenuation code, after coupling |
| att_right_ld | output | 1 | Right attenuation load flag, after coupling |
| zero_det_en | output | 1 | Zero-detect enable |
| agnd_force | output | 1 | Force outputs to analog ground |
| deemph_sel | output | 2 | De-emphasis rate select |
| mute | output | 1 | Soft mute request |
| out_type | output | 4 | Channel output routing type |
| att_couple | output | 1 | Right attenuation follows left register |
| word18 | output | 1 | 18-bit word length select |
| lr_pol | output | 1 | Frame-sync polarity select |
| fmt_i2s | output | 1 | I2S input format select |

## Verification
The bench sweeps many data values through all four addresses and compares every output bit with a decode of what was written. A shifter that reversed the bit order or sliced the address wrongly would store a corrupted word, or write the wrong register. Frames with each reserved bit set in turn, and frames of 15 and 17 clocks, must leave every output unchanged; a design that only checked the bit count, or trusted the last 16 bits, would accept them. In hardware mode, all eight pin combinations are checked, and a full frame is sent on the shared pins. A design that kept shifting in that mode would show a changed word after software mode returns. The commit latency is checked in the cycle before and the cycle after the update, which catches an extra or a missing pipeline stage.

// File: rtl/ssp_cfg_pkg.sv
// Shared sizes and reset values for the serial configuration port.
// Assumes the frame is reserved bits, then address, then data, MSB first.
package ssp_cfg_pkg;
    localparam int RES_W    = 5;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 9;
    localparam int FRAME_W  = RES_W + ADDR_W + DATA_W;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int ATT_W    = 8;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] cfg_bank_t;

    // Power-up value of one register.
    function automatic logic [DATA_W-1:0] reg_reset_value(input int idx);
        case (idx)
            0, 1:    return DATA_W'(9'h0FF);
            3:       return DATA_W'(9'h090);
            default: return '0;
        endcase
    endfunction

    // Power-up value of the whole bank.
    function automatic cfg_bank_t bank_reset_value();
        cfg_bank_t b;
        for (int i = 0; i < NUM_REGS; i++) b[i] = reg_reset_value(i);
        return b;
    endfunction
endpackage

// File: rtl/ssp_frame_rx.sv
// Serial frame receiver: oversamples the three pins with the block clock,
// shifts data on serial clock rises while the select line is high, and
// issues a one-cycle write when the select line falls after exactly one
// full frame whose reserved bits are all zero.
// Assumes pins are synchronous to clk and stable for at least two cycles.
module ssp_frame_rx
    import ssp_cfg_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_mode,
    input  logic          en,
    input  logic          sck,
    input  logic          sdi,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int FW = RW + AW + DW;
    localparam int CW = $clog2(FW + 2);

    logic [FW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          en_q, sck_q;
    logic          sck_rise, en_fall, frame_ok;

    // Edge detection and frame acceptance test.
    always_comb begin
        sck_rise = sw_mode && en && sck && !sck_q;
        en_fall  = sw_mode && en_q && !en;
        frame_ok = en_fall && (cnt == CW'(FW)) && (shreg[FW-1 -: RW] == '0);
    end

    // Remember previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            en_q  <= en;
            sck_q <= sck;
        end
    end

    // Shift serial data and count clock rises, saturating past one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (!sw_mode || !en) begin
            cnt   <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[FW-2:0], sdi};
            if (cnt != CW'(FW + 1)) cnt <= cnt + 1'b1;
        end
    end

    // Register the write request for one cycle on a valid latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= frame_ok;
            if (frame_ok) begin
                wr_addr <= shreg[DW +: AW];
                wr_data <= shreg[DW-1:0];
            end
        end
    end
endmodule

// File: rtl/ssp_reg_bank.sv
// Bank of write-only control registers loaded from the frame receiver.
// Each register resets to its own value; only the addressed one is written.
module ssp_reg_bank
    import ssp_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic [NR-1:0][DW-1:0]  words
);
    logic [DW-1:0] regs [NR];

    for (genvar i = 0; i < NR; i++) begin : g_reg
        // Load register i when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= reg_reset_value(i);
            else if (wr_en && (wr_addr == AW'(i)))
                regs[i] <= wr_data;
        end
    end

    // Present the bank as one packed vector.
    always_comb begin
        for (int i = 0; i < NR; i++) words[i] = regs[i];
    end
endmodule

// File: rtl/ssp_field_map.sv
// Decodes stored words into control outputs. In hardware mode it routes the
// shared pins to mute and de-emphasis and shows reset-value decodes elsewhere.
// Assumes field positions fixed by the register layout.
module ssp_field_map
    import ssp_cfg_pkg::*;
#(
    parameter int AT = ATT_W
) (
    input  logic          sw_mode,
    input  logic          pin_en,
    input  logic          pin_sck,
    input  logic          pin_sdi,
    input  logic [AT:0]   cfg0,
    input  logic [AT:0]   cfg1,
    input  logic [4:0]    cfg2,
    input  logic [7:0]    cfg3,
    output logic [AT-1:0] att_left,
    output logic          att_left_ld,
    output logic [AT-1:0] att_right,
    output logic          att_right_ld,
    output logic          zero_det_en,
    output logic          agnd_force,
    output logic [1:0]    deemph_sel,
    output logic          mute,
    output logic [3:0]    out_type,
    output logic          att_couple,
    output logic          word18,
    output logic          lr_pol,
    output logic          fmt_i2s
);
    localparam cfg_bank_t DEF = bank_reset_value();

    logic [AT:0] v0, v1;
    logic [4:0]  v2;
    logic [7:0]  v3;

    // Pick stored words in software mode, reset values in hardware mode.
    always_comb begin
        v0 = sw_mode ? cfg0 : DEF[0][AT:0];
        v1 = sw_mode ? cfg1 : DEF[1][AT:0];
        v2 = sw_mode ? cfg2 : DEF[2][4:0];
        v3 = sw_mode ? cfg3 : DEF[3][7:0];
    end

    // Field decode, coupling and pin override.
    always_comb begin
        att_couple   = v3[3];
        att_left     = v0[AT-1:0];
        att_left_ld  = v0[AT];
        att_right    = att_couple ? v0[AT-1:0] : v1[AT-1:0];
        att_right_ld = att_couple ? v0[AT] : v1[AT];
        zero_det_en  = v2[4];
        agnd_force   = v2[3];
        deemph_sel   = sw_mode ? v2[2:1] : {pin_sck, pin_sdi};
        mute         = sw_mode ? v2[0] : !pin_en;
        out_type     = v3[7:4];
        word18       = v3[2];
        lr_pol       = v3[1];
        fmt_i2s      = v3[0];
    end
endmodule

// File: rtl/ssp_regfile.sv
// Top of the serial configuration port: frame receiver, register bank and
// field decode. Synchronous active-low reset; pins assumed synchronous.
module ssp_regfile
    import ssp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sw,
    input  logic       pin_en,
    input  logic       pin_sck,
    input  logic       pin_sdi,
    output logic [7:0] att_left,
    output logic       att_left_ld,
    output logic [7:0] att_right,
    output logic       att_right_ld,
    output logic       zero_det_en,
    output logic       agnd_force,
    output logic [1:0] deemph_sel,
    output logic       mute,
    output logic [3:0] out_type,
    output logic       att_couple,
    output logic       word18,
    output logic       lr_pol,
    output logic       fmt_i2s
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    cfg_bank_t         words;

    ssp_frame_rx #(.RW(RES_W), .AW(ADDR_W), .DW(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_mode (mode_sw),
        .en      (pin_en),
        .sck     (pin_sck),
        .sdi     (pin_sdi),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    ssp_reg_bank #(.AW(ADDR_W), .DW(DATA_W), .NR(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .words   (words)
    );

    ssp_field_map #(.AT(ATT_W)) u_map (
        .sw_mode      (mode_sw),
        .pin_en       (pin_en),
        .pin_sck      (pin_sck),
        .pin_sdi      (pin_sdi),
        .cfg0         (words[0][ATT_W:0]),
        .cfg1         (words[1][ATT_W:0]),
        .cfg2         (words[2][4:0]),
        .cfg3         (words[3][7:0]),
        .att_left     (att_left),
        .att_left_ld  (att_left_ld),
        .att_right    (att_right),
        .att_right_ld (att_right_ld),
        .zero_det_en  (zero_det_en),
        .agnd_force   (agnd_force),
        .deemph_sel   (deemph_sel),
        .mute         (mute),
        .out_type     (out_type),
        .att_couple   (att_couple),
        .word18       (word18),
        .lr_pol       (lr_pol),
        .fmt_i2s      (fmt_i2s)
    );
endmodule

// File: rtl/ssp_regfile_chk.sv
// Property checker for ssp_regfile, attached by bind.
module ssp_regfile_chk
    import ssp_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mode_sw,
    input logic       pin_en,
    input logic       wr_en,
    input cfg_bank_t  words,
    input logic [7:0] att_left,
    input logic [7:0] att_right,
    input logic       att_couple,
    input logic       mute
);
    localparam cfg_bank_t DEF = bank_reset_value();

    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (words == DEF));

    p_write_after_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(mode_sw) && !$past(pin_en)));

    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));

    p_coupled_att_r9: assert property (@(posedge clk) disable iff (!rst_n)
        att_couple |-> (att_right == att_left));

    p_hw_mute_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sw |-> (mute == !pin_en));

    p_no_hw_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sw |=> !wr_en);
endmodule

bind ssp_regfile ssp_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sw    (mode_sw),
    .pin_en     (pin_en),
    .wr_en      (wr_en),
    .words      (words),
    .att_left   (att_left),
    .att_right  (att_right),
    .att_couple (att_couple),
    .mute       (mute)
);

// File: tb/tb_ssp_regfile.sv
`timescale 1ns/1ps
module tb_ssp_regfile;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sw = 1'b1, pin_en = 1'b0, pin_sck = 1'b0, pin_sdi = 1'b0;
    logic [7:0] att_left, att_right;
    logic att_left_ld, att_right_ld, zero_det_en, agnd_force, mute;
    logic att_couple, word18, lr_pol, fmt_i2s;
    logic [1:0] deemph_sel;
    logic [3:0] out_type;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [8:0] exp_w [4];

    always #2.5 clk = ~clk;

    ssp_regfile dut (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [30:0] got_vec();
        return {att_left, att_left_ld, att_right, att_right_ld, zero_det_en,
                agnd_force, deemph_sel, mute, out_type, att_couple, word18,
                lr_pol, fmt_i2s};
    endfunction

    // Expected outputs from the written words and the requirement decodes.
    function automatic logic [30:0] exp_vec();
        logic [8:0] e0, e1, e2, e3;
        logic cpl, mu;
        logic [1:0] de;
        if (mode_sw) begin
            e0 = exp_w[0]; e1 = exp_w[1]; e2 = exp_w[2]; e3 = exp_w[3];
        end else begin
            e0 = 9'h0FF; e1 = 9'h0FF; e2 = 9'h000; e3 = 9'h090;
        end
        cpl = e3[3];
        mu  = mode_sw ? e2[0] : !pin_en;
        de  = mode_sw ? e2[2:1] : {pin_sck, pin_sdi};
        return {e0[7:0], e0[8], cpl ? e0[7:0] : e1[7:0], cpl ? e0[8] : e1[8],
                e2[4], e2[3], de, mu, e3[7:4], cpl, e3[2], e3[1], e3[0]};
    endfunction

    task automatic check(input string tag);
        logic [30:0] g, e;
        g = got_vec();
        e = exp_vec();
        total++;
        if (g !== e) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, g, e);
        end
    endtask

    // Shift n bits, MSB first, leaving the select line high.
    task automatic shift_bits(input logic [31:0] bits, input int n);
        pin_en = 1'b1;
        tick(2);
        for (int i = n - 1; i >= 0; i--) begin
            pin_sdi = bits[i];
            pin_sck = 1'b0;
            tick(2);
            pin_sck = 1'b1;
            tick(2);
        end
        pin_sck = 1'b0;
        tick(2);
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        shift_bits(bits, n);
        pin_en = 1'b0;
        tick(4);
    endtask

    initial begin
        exp_w[0] = 9'h0FF; exp_w[1] = 9'h0FF; exp_w[2] = 9'h000; exp_w[3] = 9'h090;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R1 reset values");

        // R2 R3 R6 R7 R8: sweep data over every address
        for (int k = 0; k < 32; k++) begin
            for (int a = 0; a < 4; a++) begin
                logic [8:0] d;
                d = 9'((k * 37 + a * 101 + 5) & 9'h1FF);
                send({16'h0, 5'b0, 2'(a), d}, 16);
                exp_w[a] = d;
                case (a)
                    0, 1: check("R8 R3 R2 attenuation word");
                    2:    check("R6 R3 R2 register 2 decode");
                    default: check("R7 R3 R2 register 3 decode");
                endcase
            end
        end

        // R9 coupling on and off
        send({16'h0, 5'b0, 2'd0, 9'h1A5}, 16); exp_w[0] = 9'h1A5;
        send({16'h0, 5'b0, 2'd1, 9'h033}, 16); exp_w[1] = 9'h033;
        send({16'h0, 5'b0, 2'd3, 9'h098}, 16); exp_w[3] = 9'h098;
        check("R9 coupled right attenuation");
        send({16'h0, 5'b0, 2'd3, 9'h090}, 16); exp_w[3] = 9'h090;
        check("R9 uncoupled right attenuation");

        // R12 latency of a commit
        shift_bits({16'h0, 5'b0, 2'd2, 9'h01F}, 16);
        pin_en = 1'b0;
        tick(1);
        check("R12 no update after one edge");
        exp_w[2] = 9'h01F;
        tick(1);
        check("R12 update after two edges");
        tick(2);

        // R4 each reserved bit set discards the frame
        for (int j = 0; j < 5; j++) begin
            logic [4:0] rs;
            rs = 5'(1 << j);
            send({16'h0, rs, 2'd2, 9'h000}, 16);
            check("R4 reserved bit set");
        end

        // R5 wrong clock counts
        send({17'h0, 2'd2, 9'h000}, 15);
        check("R5 fifteen clocks");
        send({15'h0, 1'b0, 5'b0, 2'd2, 9'h000, 1'b0}, 17);
        check("R5 seventeen clocks");

        // R10 hardware mode pin routing
        pin_en = 1'b0;
        tick(2);
        mode_sw = 1'b0;
        for (int p = 0; p < 8; p++) begin
            pin_en = p[2]; pin_sck = p[1]; pin_sdi = p[0];
            tick(2);
            check("R10 hardware pin routing");
        end

        // R11 serial traffic ignored in hardware mode, words kept
        pin_en = 1'b0; pin_sck = 1'b0;
        tick(2);
        send({16'h0, 5'b0, 2'd3, 9'h000}, 16);
        send({16'h0, 5'b0, 2'd0, 9'h000}, 16);
        pin_en = 1'b1;
        tick(2);
        check("R11 hardware mode after serial traffic");
        pin_en = 1'b0;
        tick(2);
        mode_sw = 1'b1;
        tick(2);
        check("R11 words kept on return to software mode");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule